// File: doc/BRIEF.md
# Dithered Pulse Train Generator

This block drives one output bit as a bounded square-wave-like pulse train. After a start command it holds the output low for a programmable number of clock cycles. It then alternates high and low intervals. Each interval counts as one pulse and lasts a programmable base width W. The exception is the last pulse of every group of 32, which is always a low interval and lasts W+1 cycles. After 11 such groups the output returns low and stays there, the block drops busy and raises a one-cycle done strobe.

The delay and width are captured at the edge that accepts the start, so software or a neighbouring block can change them freely while a train is running. All outputs come straight from flops clocked on the rising edge.

Top module: `dithered_pulse_gen`

## Requirements
- R1: An active-low asynchronous reset forces pulse_o, busy_o and done_o low at once and returns the block to idle.
- R2: A start_i high at a rising edge while busy_o is low is accepted at that edge. busy_o is high from that edge until the train ends. delay_i and width_i are captured at that edge, and later changes to them have no effect on the running train.
- R3: The first rising edge of pulse_o occurs n rising edges after the accepting edge, where n is the captured delay. A delay of 0 behaves as 1.
- R4: From the first rising edge, pulse_o alternates high and low, starting high. Pulses 0 to 30 of each group (numbered from 0) last exactly W cycles each.
- R5: Pulse 31 of each group is low and lasts W+1 cycles. The next group then starts with a high pulse.
- R6: After 11 groups the output stays low. The train lasts 11*(32*W+1) cycles from its first rising edge.
- R7: done_o is high for exactly one cycle, starting at the edge where busy_o falls.
- R8: A start_i received while busy_o is high is ignored, and the running waveform is unchanged.
- R9: A captured width below 2 is treated as 2.
- R10: A start_i present during the cycle in which done_o is high is accepted, since the block is idle then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled at the rising edge |
| delay_i | input | DLY_W (16) | Cycles from accepting edge to first rising edge |
| width_i | input | WID_W (12) | Base pulse width W in cycles |
| pulse_o | output | 1 | Pulse train output |
| busy_o | output | 1 | High while a train is in progress |
| done_o | output | 1 | One-cycle strobe when the train ends |

## Verification
Two events can fall in the same cycle here. The end-of-train strobe can coincide with a new start request, and a start request can arrive while the final stretched low pulse is still running. The bench raises start_i exactly in the done cycle and checks that busy_o is high right after the next edge. It also pulses start_i with different delay and width values partway through a train, and requires the whole cycle-by-cycle waveform and the total busy length to match the model built from the first captured values.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } dpt_state_e;
endpackage

// File: rtl/dpt_down_cnt.sv
module dpt_down_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             en_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  // value 0 and 1 both end the interval on this edge
  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/dpt_seq_cnt.sv
module dpt_seq_cnt #(
  parameter int PULSES = 32,
  parameter int GROUPS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic next_last_o,
  output logic final_o
);
  localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [PW-1:0] pulse_q;
  logic [GW-1:0] group_q;
  logic          pulse_last;
  logic          group_last;

  assign pulse_last  = (pulse_q == PW'(PULSES - 1));
  assign next_last_o = (pulse_q == PW'(PULSES - 2));

  generate
    if (GROUPS > 1) begin : g_multi
      assign group_last = (group_q == GW'(GROUPS - 1));
    end else begin : g_single
      assign group_last = (group_q == '0);
    end
  endgenerate

  assign final_o = pulse_last && group_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      group_q <= '0;
    end else if (clr_i) begin
      pulse_q <= '0;
      group_q <= '0;
    end else if (step_i) begin
      if (pulse_last) begin
        pulse_q <= '0;
        group_q <= group_last ? '0 : group_q + GW'(1);
      end else begin
        pulse_q <= pulse_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/dithered_pulse_gen.sv
module dithered_pulse_gen
  import dpt_pkg::*;
#(
  parameter int DLY_W  = 16,
  parameter int WID_W  = 12,
  parameter int PULSES = 32,
  parameter int GROUPS = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [WID_W-1:0] width_i,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_W = (DLY_W > WID_W + 1) ? DLY_W : WID_W + 1;

  dpt_state_e       state_q;
  logic             pulse_q;
  logic             done_q;
  logic [WID_W-1:0] width_q;

  logic             cnt_last;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             seq_clr;
  logic             seq_step;
  logic             seq_next_last;
  logic             seq_final;
  logic             accept;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign seq_clr  = (state_q == ST_DELAY) && cnt_last;
  assign seq_step = (state_q == ST_RUN) && cnt_last;
  assign cnt_load = accept || seq_clr || (seq_step && !seq_final);

  // next interval length: delay, base width, or stretched width
  always_comb begin
    if (state_q == ST_IDLE)
      cnt_val = CNT_W'(delay_i);
    else if (seq_step && seq_next_last)
      cnt_val = CNT_W'(width_q) + CNT_W'(1);
    else
      cnt_val = CNT_W'(width_q);
  end

  dpt_down_cnt #(.CNT_W(CNT_W)) i_width_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .en_i   (state_q != ST_IDLE),
    .last_o (cnt_last)
  );

  dpt_seq_cnt #(.PULSES(PULSES), .GROUPS(GROUPS)) i_seq_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (seq_clr),
    .step_i      (seq_step),
    .next_last_o (seq_next_last),
    .final_o     (seq_final)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
      width_q <= WID_W'(2);
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_DELAY;
            width_q <= (width_i < WID_W'(2)) ? WID_W'(2) : width_i;
          end
        end
        ST_DELAY: begin
          if (cnt_last) begin
            state_q <= ST_RUN;
            pulse_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt_last) begin
            if (seq_final) begin
              state_q <= ST_IDLE;
              pulse_q <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              pulse_q <= ~pulse_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse_o = pulse_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pulse_o,
  input logic busy_o,
  input logic done_o
);
  assert_done_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_on_busy_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o || $past(start_i)) && $past(busy_o));

  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pulse_o);

  assert_min_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |=> pulse_o);

  assert_min_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pulse_o) && busy_o) |=> !pulse_o);

  assert_start_accepted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_rise_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> ($past(busy_o) && busy_o));
endmodule

bind dithered_pulse_gen dpt_checker i_dpt_checker (.*);

// File: tb/test_dithered_pulse_gen.sv
`timescale 1ns/1ps
module test_dithered_pulse_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] delay_i = '0;
  logic [11:0] width_i = '0;
  logic        pulse_o, busy_o, done_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk_i = ~clk_i;

  dithered_pulse_gen i_dithered_pulse_gen (
    .clk_i, .rst_ni, .start_i, .delay_i, .width_i,
    .pulse_o, .busy_o, .done_o
  );

  // delay, width, expected busy length, poke start mid-run
  localparam int NV = 6;
  localparam int VEC_N[NV]   = '{1,   5,    0,   3,   2,    4};
  localparam int VEC_W[NV]   = '{2,   3,    2,   1,   4,    0};
  localparam int VEC_LEN[NV] = '{716, 1072, 716, 718, 1421, 719};
  localparam bit VEC_POKE[NV] = '{0,  1,    0,   0,   1,    0};

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives one train from the current negedge; chain=1 starts a new one in the done cycle
  task automatic run_seq(input int n, input int w, input int exp_len, input bit poke,
                         input bit chain);
    int ne, we, grp, total, u, r;
    int bad_r3, bad_r4, bad_r5, bad_r6, bad_busy, bad_done, busy_len, rises;
    int first_r3, first_r4, first_r5, first_r6;
    bit exp_p, prev_p;
    ne = (n < 1) ? 1 : n;
    we = (w < 2) ? 2 : w;
    grp = 32 * we + 1;
    total = ne + 11 * grp;
    bad_r3 = 0; bad_r4 = 0; bad_r5 = 0; bad_r6 = 0;
    bad_busy = 0; bad_done = 0; busy_len = 0; rises = 0; prev_p = 0;
    first_r3 = -1; first_r4 = -1; first_r5 = -1; first_r6 = -1;
    delay_i = 16'(n); width_i = 12'(w); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    delay_i = 16'hffff; width_i = 12'd9;   // R2: later changes must not matter
    for (int t = 0; t <= total + 1; t++) begin
      if (poke && t == 20)  begin start_i = 1'b1; delay_i = 16'd0; width_i = 12'd7; end
      if (poke && t == 21)  start_i = 1'b0;
      if (poke && t == total - 3) start_i = 1'b1;  // during final stretched pulse
      if (poke && t == total - 2) start_i = 1'b0;
      if (chain && t == total) begin start_i = 1'b1; delay_i = 16'd2; width_i = 12'd2; end
      if (t < ne) exp_p = 1'b0;
      else if (t >= total) exp_p = 1'b0;
      else begin
        u = t - ne;
        r = u % grp;
        exp_p = (r < 31 * we) ? (((r / we) % 2) == 0) : 1'b0;
      end
      if (pulse_o !== exp_p) begin
        if (t < ne) begin bad_r3++; if (first_r3 < 0) first_r3 = t; end
        else if (t >= total) begin bad_r6++; if (first_r6 < 0) first_r6 = t; end
        else if (((t - ne) % grp) >= 31 * we) begin bad_r5++; if (first_r5 < 0) first_r5 = t; end
        else begin bad_r4++; if (first_r4 < 0) first_r4 = t; end
      end
      if (t <= total && busy_o !== (t < total)) bad_busy++;
      if (done_o !== (t == total)) bad_done++;
      if (busy_o === 1'b1 && t <= total) busy_len++;
      if (pulse_o === 1'b1 && !prev_p) rises++;
      prev_p = (pulse_o === 1'b1);
      if (t == total + 1 && chain) begin
        start_i = 1'b0;
        check("R10 start in done cycle accepted", busy_o === 1'b1, busy_o, 1);
      end
      if (t < total + 1) @(negedge clk_i);
    end
    check((n < 1) ? "R3 delay zero as one" : "R3 first rise after delay", bad_r3 == 0, first_r3, -1);
    check("R4 normal pulse widths", bad_r4 == 0, first_r4, -1);
    check("R5 stretched low pulse", bad_r5 == 0, first_r5, -1);
    check("R6 stays low after 11 groups", bad_r6 == 0, first_r6, -1);
    check("R6 rising edge count", rises == 11 * 16, rises, 11 * 16);
    check("R2 busy length", busy_len == exp_len, busy_len, exp_len);
    check("R2 busy profile", bad_busy == 0, bad_busy, 0);
    check("R7 done strobe", bad_done == 0, bad_done, 0);
    if (w < 2) check("R9 width clamp", bad_r4 + bad_r5 == 0, bad_r4 + bad_r5, 0);
    if (poke)  check("R8 start while busy ignored", bad_r3 + bad_r4 + bad_r5 + bad_busy == 0,
                     bad_r3 + bad_r4 + bad_r5 + bad_busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset pulse", pulse_o === 1'b0, pulse_o, 0);
    check("R1 reset busy",  busy_o  === 1'b0, busy_o, 0);
    check("R1 reset done",  done_o  === 1'b0, done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", busy_o === 1'b0 && pulse_o === 1'b0, busy_o, 0);

    for (int i = 0; i < NV; i++)
      run_seq(VEC_N[i], VEC_W[i], VEC_LEN[i], VEC_POKE[i], 1'b0);

    // R10: back-to-back start in the done cycle, then R1 mid-run reset
    @(negedge clk_i);
    run_seq(1, 2, 716, 1'b0, 1'b1);
    @(negedge clk_i);                    // t'=1 of new train: still delaying
    check("R10 chained train delay", pulse_o === 1'b0, pulse_o, 0);
    @(negedge clk_i);                    // t'=2: first rise
    check("R10 chained train rises", pulse_o === 1'b1, pulse_o, 1);
    #0.5 rst_ni = 1'b0;
    #0.5;
    check("R1 async reset pulse", pulse_o === 1'b0, pulse_o, 0);
    check("R1 async reset busy",  busy_o  === 1'b0, busy_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 stays idle", busy_o === 1'b0 && done_o === 1'b0, busy_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule